// File: doc/BRIEF.md
# Forwarding and Load-Use Interlock Unit

This block holds the hazard control for a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory and writeback. The register file is read only in decode and written only in writeback. Because of this, the only hazard the block has to resolve is read-after-write. Younger results are routed to the two ALU operand inputs from the execute/memory and memory/writeback pipeline registers. When a load is followed at once by an instruction that needs the loaded value, the block holds fetch and decode for one cycle and sends a bubble down the execute stage.

The block contains a light model of the four pipeline registers. Each register carries only the fields that the hazard logic needs: source and destination numbers, write enable, load and store flags. Decode fields enter through the fetch-side ports. The selects and the stage contents come out so that the surrounding datapath, or a bench, can observe them. The bypass selects are worked out while the consumer is still in decode and are then registered into the execute stage, so the execute stage receives ready-made mux selects.

Top module: `fwd_interlock_unit`

## Requirements
- R1: After a synchronous active-high reset, all stage controls are cleared. This means `stall` low, both selects 2'b00, and every write, load and store flag low.
- R2: Select encoding per operand: 2'b00 means register file, 2'b10 means execute/memory result, 2'b01 means memory/writeback result. An operand in execute gets 2'b10 when the instruction now in the memory stage writes its source register.
- R3: An operand gets 2'b01 when the writeback-stage instruction writes its source register and the memory-stage instruction does not.
- R4: When both later stages write the same source register, the memory-stage (younger) result wins and the select is 2'b10.
- R5: Register 0 is never forwarded and never causes a stall. A producer with its write enable low is never forwarded from.
- R6: The two operands are selected independently. A store's data operand (second source) is forwarded by the same rule as an ALU operand.
- R7: `stall` is high, in the same cycle, while a load with write enable and a nonzero destination sits in execute and the decode instruction reads that register through a source it marks as used.
- R8: While `stall` is high, the decode instruction is held and the fetch-side inputs are ignored. The held instruction enters execute on the cycle after the stall.
- R9: The execute stage entered in the cycle after a stall is a bubble: valid, write, load and store flags low and both selects 2'b00.
- R10: One load causes exactly one stall cycle. The dependent instruction then receives the loaded value via select 2'b01.
- R11: A source marked unused never causes a stall, even when its number matches a load destination.
- R12: A fetch with `if_valid` low enters decode as a bubble with no register effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_valid | input | 1 | Fetched instruction is real |
| if_rs1 | input | AW | First source register number |
| if_rs2 | input | AW | Second source register number (store data) |
| if_use_rs1 | input | 1 | First source is read |
| if_use_rs2 | input | 1 | Second source is read |
| if_rd | input | AW | Destination register number |
| if_wen | input | 1 | Instruction writes a register |
| if_load | input | 1 | Instruction is a load |
| if_store | input | 1 | Instruction is a store |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| ex_sel_a | output | 2 | Bypass select for the first ALU operand |
| ex_sel_b | output | 2 | Bypass select for the second operand / store data |
| ex_valid | output | 1 | Execute stage holds a real instruction |
| ex_rd | output | AW | Execute-stage destination |
| ex_wen | output | 1 | Execute-stage write enable |
| ex_load | output | 1 | Execute-stage load flag |
| ex_store | output | 1 | Execute-stage store flag |
| mem_rd | output | AW | Memory-stage destination |
| mem_wen | output | 1 | Memory-stage write enable |
| wb_rd | output | AW | Writeback-stage destination |
| wb_wen | output | 1 | Writeback-stage write enable |

## Verification
The hardest situation to reach is a load-use stall where the held instruction, on its retry, also matches an older writer in writeback. A related case is a stall whose ignored fetch inputs carry a conflicting instruction. Both need a particular three-instruction history. The random stimulus draws all register numbers from a pool of four, with register 0 included, and often emits loads. Directed sequences then force the exact load-use, priority, register-0, unused-source and store-data patterns. Fetch inputs are filled with random junk during every stall.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] prod_rd,
  input  logic          prod_wen,
  output logic          hit
);
  // a producer counts only if it really writes a nonzero register
  always_comb hit = prod_wen && (prod_rd != '0) && (prod_rd == src);
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] near_rd,   // will be in EX/MEM next cycle
  input  logic          near_wen,
  input  logic [AW-1:0] far_rd,    // will be in MEM/WB next cycle
  input  logic          far_wen,
  output fwd_sel_e      sel
);
  logic near_hit, far_hit;

  hz_src_match #(.AW(AW)) u_near (
    .src(src), .prod_rd(near_rd), .prod_wen(near_wen), .hit(near_hit)
  );
  hz_src_match #(.AW(AW)) u_far (
    .src(src), .prod_rd(far_rd), .prod_wen(far_wen), .hit(far_hit)
  );

  // younger result has priority
  always_comb begin
    if (near_hit)     sel = SEL_EXMEM;
    else if (far_hit) sel = SEL_MEMWB;
    else              sel = SEL_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [NUM_SRC-1:0][AW-1:0] src,
  input  logic [NUM_SRC-1:0]         src_used,
  input  logic [AW-1:0]              ex_rd,
  input  logic                       ex_wen,
  input  logic                       ex_is_load,
  output logic                       stall
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hz_src_match #(.AW(AW)) u_m (
      .src(src[g]), .prod_rd(ex_rd), .prod_wen(ex_wen && ex_is_load), .hit(hit[g])
    );
  end

  always_comb stall = |(hit & src_used);
endmodule

// File: rtl/hz_stage_reg.sv
module hz_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= d;
  end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          if_valid,
  input  logic [AW-1:0] if_rs1,
  input  logic [AW-1:0] if_rs2,
  input  logic          if_use_rs1,
  input  logic          if_use_rs2,
  input  logic [AW-1:0] if_rd,
  input  logic          if_wen,
  input  logic          if_load,
  input  logic          if_store,
  output logic          stall,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic          ex_valid,
  output logic [AW-1:0] ex_rd,
  output logic          ex_wen,
  output logic          ex_load,
  output logic          ex_store,
  output logic [AW-1:0] mem_rd,
  output logic          mem_wen,
  output logic [AW-1:0] wb_rd,
  output logic          wb_wen
);

  // decode-stage view
  typedef struct packed {
    logic          valid;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic          use1;
    logic          use2;
    logic [AW-1:0] rd;
    logic          wen;
    logic          ld;
    logic          st;
  } dec_t;

  // execute stage needs no source numbers: selects are precomputed
  typedef struct packed {
    logic          valid;
    logic [AW-1:0] rd;
    logic          wen;
    logic          ld;
    logic          st;
    logic [1:0]    sel_a;
    logic [1:0]    sel_b;
  } exe_t;

  typedef struct packed {
    logic [AW-1:0] rd;
    logic          wen;
  } dst_t;

  localparam int unsigned DEC_W = $bits(dec_t);
  localparam int unsigned EXE_W = $bits(exe_t);
  localparam int unsigned DST_W = $bits(dst_t);

  dec_t fetch_op, ifid_q;
  exe_t idex_d, idex_q;
  dst_t exmem_d, exmem_q, memwb_q;

  logic [NUM_SRC-1:0][AW-1:0] dec_src;
  logic [NUM_SRC-1:0]         dec_used;
  fwd_sel_e [NUM_SRC-1:0]     dec_sel;
  logic                       hold;

  // an invalid fetch enters as an all-zero bubble
  always_comb begin
    fetch_op = '0;
    if (if_valid) begin
      fetch_op.valid = 1'b1;
      fetch_op.rs1   = if_rs1;
      fetch_op.rs2   = if_rs2;
      fetch_op.use1  = if_use_rs1;
      fetch_op.use2  = if_use_rs2;
      fetch_op.rd    = if_rd;
      fetch_op.wen   = if_wen;
      fetch_op.ld    = if_load;
      fetch_op.st    = if_store;
    end
  end

  hz_stage_reg #(.W(DEC_W)) u_ifid (
    .clk(clk), .rst(rst), .en(!hold), .clr(1'b0), .d(fetch_op), .q(ifid_q)
  );

  always_comb begin
    dec_src[0]  = ifid_q.rs1;
    dec_src[1]  = ifid_q.rs2;
    dec_used[0] = ifid_q.use1;
    dec_used[1] = ifid_q.use2;
  end

  // select chosen one stage early: ID/EX becomes EX/MEM, EX/MEM becomes MEM/WB
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
    hz_fwd_pick #(.AW(AW)) u_pick (
      .src(dec_src[g]),
      .near_rd(idex_q.rd), .near_wen(idex_q.wen),
      .far_rd(exmem_q.rd), .far_wen(exmem_q.wen),
      .sel(dec_sel[g])
    );
  end

  hz_load_use #(.AW(AW)) u_lu (
    .src(dec_src), .src_used(dec_used),
    .ex_rd(idex_q.rd), .ex_wen(idex_q.wen), .ex_is_load(idex_q.ld),
    .stall(hold)
  );

  always_comb begin
    idex_d.valid = ifid_q.valid;
    idex_d.rd    = ifid_q.rd;
    idex_d.wen   = ifid_q.wen;
    idex_d.ld    = ifid_q.ld;
    idex_d.st    = ifid_q.st;
    idex_d.sel_a = dec_sel[0];
    idex_d.sel_b = dec_sel[1];
  end

  // a stall clears ID/EX, which is the bubble
  hz_stage_reg #(.W(EXE_W)) u_idex (
    .clk(clk), .rst(rst), .en(1'b1), .clr(hold), .d(idex_d), .q(idex_q)
  );

  always_comb begin
    exmem_d.rd  = idex_q.rd;
    exmem_d.wen = idex_q.wen;
  end

  hz_stage_reg #(.W(DST_W)) u_exmem (
    .clk(clk), .rst(rst), .en(1'b1), .clr(1'b0), .d(exmem_d), .q(exmem_q)
  );

  hz_stage_reg #(.W(DST_W)) u_memwb (
    .clk(clk), .rst(rst), .en(1'b1), .clr(1'b0), .d(exmem_q), .q(memwb_q)
  );

  always_comb begin
    stall    = hold;
    ex_sel_a = idex_q.sel_a;
    ex_sel_b = idex_q.sel_b;
    ex_valid = idex_q.valid;
    ex_rd    = idex_q.rd;
    ex_wen   = idex_q.wen;
    ex_load  = idex_q.ld;
    ex_store = idex_q.st;
    mem_rd   = exmem_q.rd;
    mem_wen  = exmem_q.wen;
    wb_rd    = memwb_q.rd;
    wb_wen   = memwb_q.wen;
  end

endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic [1:0]    ex_sel_a,
  input logic [1:0]    ex_sel_b,
  input logic          ex_valid,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic          ex_store,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic [AW-1:0] wb_rd,
  input logic          wb_wen
);

  a_r7_stall_needs_load: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_load && ex_wen && ex_rd != '0));

  a_r9_bubble_after_stall: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!ex_valid && !ex_wen && !ex_load && !ex_store &&
               ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

  a_r10_single_stall: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  a_r2_sel_a_exmem: assert property (@(posedge clk) disable iff (rst)
    (ex_sel_a == 2'b10) |-> (mem_wen && mem_rd != '0));

  a_r2_sel_b_exmem: assert property (@(posedge clk) disable iff (rst)
    (ex_sel_b == 2'b10) |-> (mem_wen && mem_rd != '0));

  a_r3_sel_a_memwb: assert property (@(posedge clk) disable iff (rst)
    (ex_sel_a == 2'b01) |-> (wb_wen && wb_rd != '0));

  a_r3_sel_b_memwb: assert property (@(posedge clk) disable iff (rst)
    (ex_sel_b == 2'b01) |-> (wb_wen && wb_rd != '0));

  a_r2_sel_legal: assert property (@(posedge clk) disable iff (rst)
    (ex_sel_a != 2'b11) && (ex_sel_b != 2'b11));

endmodule

bind fwd_interlock_unit hz_checker #(.AW(AW)) u_hz_checker (
  .clk(clk), .rst(rst), .stall(stall),
  .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .ex_valid(ex_valid),
  .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load), .ex_store(ex_store),
  .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen)
);

// File: tb/tb_fwd_interlock_unit.sv
module tb_fwd_interlock_unit;
  localparam int unsigned AW = 5;

  typedef struct packed {
    logic          valid;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic          u1;
    logic          u2;
    logic [AW-1:0] rd;
    logic          wen;
    logic          ld;
    logic          st;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          if_valid, if_use_rs1, if_use_rs2, if_wen, if_load, if_store;
  logic [AW-1:0] if_rs1, if_rs2, if_rd;
  logic          stall, ex_valid, ex_wen, ex_load, ex_store, mem_wen, wb_wen;
  logic [1:0]    ex_sel_a, ex_sel_b;
  logic [AW-1:0] ex_rd, mem_rd, wb_rd;

  fwd_interlock_unit #(.AW(AW)) dut (
    .clk(clk), .rst(rst),
    .if_valid(if_valid), .if_rs1(if_rs1), .if_rs2(if_rs2),
    .if_use_rs1(if_use_rs1), .if_use_rs2(if_use_rs2),
    .if_rd(if_rd), .if_wen(if_wen), .if_load(if_load), .if_store(if_store),
    .stall(stall), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .ex_load(ex_load), .ex_store(ex_store),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen)
  );

  int   errors = 0;
  int   checks = 0;
  int   cycles = 0;
  bit   done_flag = 0;
  ins_t m_ifid, m_idex, m_exm, m_mwb;
  string dtag = "";
  int   stalls_seen = 0;

  always @(posedge clk) cycles <= cycles + 1;

  function automatic bit writes(ins_t p, logic [AW-1:0] src);
    return p.valid && p.wen && p.rd != '0 && p.rd == src;
  endfunction

  function automatic logic [1:0] exp_sel(logic [AW-1:0] src, ins_t e, ins_t w);
    if (writes(e, src)) return 2'b10;
    if (writes(w, src)) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(logic [AW-1:0] src, ins_t e, ins_t w);
    if (writes(e, src) && writes(w, src)) return "R4";
    if (writes(e, src)) return "R2";
    if (writes(w, src)) return "R3";
    return "R5";
  endfunction

  function automatic bit exp_stall(ins_t d, ins_t x);
    return x.valid && x.ld && x.wen && x.rd != '0 &&
           ((d.u1 && d.rs1 == x.rd) || (d.u2 && d.rs2 == x.rd));
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s%s %s: got %0d expected %0d (cycle %0d)", tag, dtag, what, got, exp, cycles);
    end
  endtask

  function automatic ins_t rnd_ins();
    ins_t x;
    int k;
    x = '0;
    x.valid = ($urandom_range(0, 9) != 0);
    x.rs1 = AW'($urandom_range(0, 3));
    x.rs2 = AW'($urandom_range(0, 3));
    x.rd  = AW'($urandom_range(0, 3));
    x.u1  = ($urandom_range(0, 4) != 0);
    x.u2  = ($urandom_range(0, 1) != 0);
    k = $urandom_range(0, 9);
    if (k < 3)      begin x.ld = 1'b1; x.wen = 1'b1; end
    else if (k < 5) begin x.st = 1'b1; x.u2 = 1'b1; end
    else            x.wen = ($urandom_range(0, 4) != 0);
    if (!x.valid) x = '0;
    return x;
  endfunction

  task automatic drive(ins_t x);
    if_valid = x.valid; if_rs1 = x.rs1; if_rs2 = x.rs2;
    if_use_rs1 = x.u1; if_use_rs2 = x.u2; if_rd = x.rd;
    if_wen = x.wen; if_load = x.ld; if_store = x.st;
  endtask

  // one cycle: check at negedge, drive, model the edge
  task automatic cyc(ins_t x, output bit taken);
    bit s;
    ins_t drv;
    @(negedge clk);
    s = exp_stall(m_ifid, m_idex);
    chk("R7", "stall", stall, s);
    chk("R9", "ex_valid", ex_valid, m_idex.valid);
    chk("R9", "ex_wen", ex_wen, m_idex.wen);
    chk("R9", "ex_load", ex_load, m_idex.ld);
    chk("R9", "ex_store", ex_store, m_idex.st);
    chk("R8", "ex_rd", ex_rd, m_idex.rd);
    chk(sel_tag(m_idex.rs1, m_exm, m_mwb), "sel_a", ex_sel_a, exp_sel(m_idex.rs1, m_exm, m_mwb));
    chk(sel_tag(m_idex.rs2, m_exm, m_mwb), "sel_b", ex_sel_b, exp_sel(m_idex.rs2, m_exm, m_mwb));
    if (s) begin
      stalls_seen++;
      drv = rnd_ins();   // R8: must be ignored
      drv.valid = 1'b1;
      taken = 1'b0;
    end else begin
      drv = x;
      taken = 1'b1;
    end
    drive(drv);
    @(posedge clk);
    #1;
    m_mwb  = m_exm;
    m_exm  = m_idex;
    m_idex = s ? ins_t'('0) : m_ifid;
    if (!s) m_ifid = drv.valid ? drv : ins_t'('0);
  endtask

  task automatic push(ins_t x);
    bit t;
    t = 1'b0;
    while (!t) cyc(x, t);
  endtask

  function automatic ins_t mk(bit v, int rs1, int rs2, bit u1, bit u2, int rd,
                              bit wen, bit ld, bit st);
    ins_t x;
    x.valid = v; x.rs1 = AW'(rs1); x.rs2 = AW'(rs2); x.u1 = u1; x.u2 = u2;
    x.rd = AW'(rd); x.wen = wen; x.ld = ld; x.st = st;
    return x;
  endfunction

  task automatic flush();
    for (int i = 0; i < 4; i++) push('0);
  endtask

  initial begin : watchdog
    wait (cycles >= 200000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int s0;
    void'($urandom(32'h5eed_1234));
    drive('0);
    m_ifid = '0; m_idex = '0; m_exm = '0; m_mwb = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    chk("R1", "stall", stall, 0);
    chk("R1", "sel_a", ex_sel_a, 0);
    chk("R1", "sel_b", ex_sel_b, 0);
    chk("R1", "mem_wen", mem_wen, 0);
    chk("R1", "wb_wen", wb_wen, 0);

    // R2/R3/R4: double writer of r1, then reader
    dtag = " R4";
    push(mk(1, 0, 0, 0, 0, 1, 1, 0, 0));
    push(mk(1, 0, 0, 0, 0, 1, 1, 0, 0));
    push(mk(1, 1, 1, 1, 1, 2, 1, 0, 0));
    flush();

    // R5: write r0 then read r0; wen-low producer of r2
    dtag = " R5";
    push(mk(1, 0, 0, 0, 0, 0, 1, 1, 0));
    push(mk(1, 0, 0, 1, 1, 3, 1, 0, 0));
    push(mk(1, 0, 0, 0, 0, 2, 0, 0, 0));
    push(mk(1, 2, 2, 1, 1, 1, 1, 0, 0));
    flush();

    // R6: store data from a writer two ahead, address from the next one
    dtag = " R6";
    push(mk(1, 0, 0, 0, 0, 3, 1, 0, 0));
    push(mk(1, 0, 0, 0, 0, 2, 1, 0, 0));
    push(mk(1, 2, 3, 1, 1, 0, 0, 0, 1));
    flush();

    // R10: load-use, exactly one stall, then 01
    dtag = " R10";
    s0 = stalls_seen;
    push(mk(1, 0, 0, 1, 0, 2, 1, 1, 0));
    push(mk(1, 2, 0, 1, 0, 1, 1, 0, 0));
    flush();
    chk("R10", "stall count", stalls_seen - s0, 1);

    // R11: matching but unused source does not stall
    dtag = " R11";
    s0 = stalls_seen;
    push(mk(1, 0, 0, 0, 0, 3, 1, 1, 0));
    push(mk(1, 1, 3, 1, 0, 1, 1, 0, 0));
    flush();
    chk("R11", "stall count", stalls_seen - s0, 0);

    // R12: invalid fetch carrying a writer pattern becomes a bubble
    dtag = " R12";
    push(mk(0, 0, 0, 0, 0, 1, 1, 1, 0));
    push(mk(1, 1, 1, 1, 1, 2, 1, 0, 0));
    flush();

    dtag = "";
    for (int i = 0; i < 3000; i++) push(rnd_ins());
    flush();

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule